// File: doc/BRIEF.md
# Sleep-wake error supervisory timer

This block guards a low-power bus transceiver node against staying in a high-power state after a fault. It watches the node's current mode. When the node enters a mode in which it may hang, the block starts a long timeout counted on an external slow enable tick. Those modes are restart and fail-safe in either control style, and standby as well when the node runs under serial control. If nothing clears the condition before the count runs out, the block raises a one-cycle timeout pulse. It also holds a request for the node to move to sleep or to fail-safe.

The conditions that cancel a count depend on the mode. In restart, the regulated supply rising above its undervoltage threshold (`vcc_good_i`) cancels the count. In standby, a completed serial transaction from the host (`spi_done_i`) cancels it. The timeout length and an enable bit live in one configuration byte at register address 0x1C. That byte can be read and written over a simple register port. The tick parameter `TICKS_PER_SEC` sets how many `tick_i` pulses form one second, so a bench can run long timeouts quickly.

Top module: `swe_supervisor`

## Requirements
- R1: After a synchronous reset, the configuration byte reads 0x30, which means the timer is enabled and the duration code is 6. After reset, `timeout_o` and `req_valid_o` are low.
- R2: A write with `reg_we_i` high and `reg_addr_i` = 0x1C stores `reg_wdata_i`. Writes to any other address leave the byte unchanged. `reg_rdata_o` shows the byte one cycle after `reg_addr_i` = 0x1C is presented, and shows 0 for any other address.
- R3: The duration code is bits 6:3 of the byte. It maps to a timeout in seconds: code 0 gives 30 s, code 1 gives 60 s, codes 2 to 14 give 30*(code+4) s, and code 15 gives 600 s. Code 6 therefore gives 300 s. The count expires on the (seconds*TICKS_PER_SEC)-th `tick_i` pulse after the mode entry.
- R4: The mode codes are 0 sleep, 1 standby, 2 restart, 3 fail-safe and 4 normal. With `serial_i` = 0 (pin style), the count starts on each entry to restart or fail-safe. In pin style, entering standby starts no count.
- R5: With `serial_i` = 1 (serial style) and the timer enabled, the count starts on each entry to restart, fail-safe or standby.
- R6: In restart, `vcc_good_i` high stops and clears the count. If the count expires in restart, the request is sleep (0).
- R7: In serial-style standby, a `spi_done_i` pulse stops and clears the count. If the count expires in standby, the request is fail-safe (3) when `fs_en_i` = 1 and sleep (0) when `fs_en_i` = 0.
- R8: If the count expires in fail-safe, the request is sleep (0).
- R9: Bit 7 of the byte set to 1 disables the timer in serial style only. In pin style the timer stays active whatever bit 7 holds.
- R10: Leaving the qualifying mode stops and clears the count. A later re-entry counts the full duration again from zero.
- R11: On expiry, `timeout_o` is high for exactly one cycle. `req_valid_o` and `req_mode_o` hold until `mode_i` equals `req_mode_o`, and `req_valid_o` drops one cycle after that.
- R12: A change of duration code during a count takes effect at once against the ticks already counted. If the count already meets the new limit, the count expires on the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Slow enable tick, TICKS_PER_SEC pulses per second |
| mode_i | input | 3 | Current node mode code |
| serial_i | input | 1 | 1 = serial control style, 0 = pin control style |
| vcc_good_i | input | 1 | Regulated supply above undervoltage threshold |
| spi_done_i | input | 1 | One-cycle pulse: host serial transaction completed |
| fs_en_i | input | 1 | Fail-safe mode enabled |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 8 | Registered read data |
| timeout_o | output | 1 | One-cycle expiry pulse |
| req_valid_o | output | 1 | Next-mode request pending |
| req_mode_o | output | 3 | Requested next mode code |

## Verification
A counter holding a wrong value shows at the ports as a timeout pulse on the wrong tick. The bench therefore counts the ticks from each mode entry and demands the pulse on exactly the tick the duration code predicts, and on no tick before it. A run flag stuck high or low shows as a pulse after an abort or a disable, or as no pulse at all. Each of these is caught within one timeout length. A wrong target or a wrong request hold shows in `req_mode_o`, or as `req_valid_o` clearing early or late. This is visible in the cycle after the expiry or after the mode change.

// File: rtl/swe_pkg.sv
package swe_pkg;
  localparam logic [2:0] M_SLEEP    = 3'd0;
  localparam logic [2:0] M_STANDBY  = 3'd1;
  localparam logic [2:0] M_RESTART  = 3'd2;
  localparam logic [2:0] M_FAILSAFE = 3'd3;
  localparam logic [2:0] M_NORMAL   = 3'd4;

  localparam int unsigned MAX_SECS = 600;

  // Duration code to seconds.
  function automatic int unsigned secs_of(input logic [3:0] code);
    int unsigned s;
    if (code == 4'd0)       s = 30;
    else if (code == 4'd1)  s = 60;
    else if (code == 4'd15) s = MAX_SECS;
    else                    s = 30 * (int'(code) + 4);
    return s;
  endfunction
endpackage

// File: rtl/swe_cfg_reg.sv
module swe_cfg_reg #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] REG_ADDR = 8'h1C,
  parameter logic [DW-1:0] RESET_VAL = 8'h30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] cfg_o
);
  logic hit;
  assign hit = (addr_i == REG_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o   <= RESET_VAL;
      rdata_o <= '0;
    end else begin
      if (we_i && hit) cfg_o <= wdata_i;
      rdata_o <= hit ? cfg_o : '0;
    end
  end

  // R2: no write strobe at this address keeps the byte
  p_reg_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!(we_i && hit)) |=> $stable(cfg_o));
endmodule

// File: rtl/swe_limit.sv
module swe_limit #(
  parameter int unsigned TICKS_PER_SEC = 1,
  parameter int unsigned CNT_W = 10
) (
  input  logic [3:0]       code_i,
  output logic [CNT_W-1:0] limit_o
);
  import swe_pkg::*;
  always_comb begin
    limit_o = CNT_W'(secs_of(code_i) * TICKS_PER_SEC);
  end
endmodule

// File: rtl/swe_count.sv
module swe_count #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic [2:0]       mode_i,
  input  logic             serial_i,
  input  logic             dis_i,
  input  logic             vcc_good_i,
  input  logic             spi_done_i,
  input  logic             fs_en_i,
  output logic             timeout_o,
  output logic             req_valid_o,
  output logic [2:0]       req_mode_o
);
  import swe_pkg::*;

  logic [2:0]       mode_q;
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             qual, enabled, entry, abort_c, stop_c, expire;
  logic [2:0]       target;

  always_comb begin
    qual    = (mode_i == M_RESTART) || (mode_i == M_FAILSAFE) ||
              (serial_i && (mode_i == M_STANDBY));
    enabled = !serial_i || !dis_i;
    entry   = qual && (mode_i != mode_q);
    abort_c = ((mode_i == M_RESTART) && vcc_good_i) ||
              ((mode_i == M_STANDBY) && spi_done_i);
    stop_c  = !qual || !enabled || abort_c;
    cnt_inc = cnt_q + 1'b1;
    expire  = !stop_c && !entry && run_q && tick_i && (cnt_inc >= limit_i);
    if (mode_i == M_STANDBY) target = fs_en_i ? M_FAILSAFE : M_SLEEP;
    else                     target = M_SLEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= M_NORMAL;
      run_q       <= 1'b0;
      cnt_q       <= '0;
      timeout_o   <= 1'b0;
      req_valid_o <= 1'b0;
      req_mode_o  <= M_SLEEP;
    end else begin
      mode_q    <= mode_i;
      timeout_o <= 1'b0;
      if (req_valid_o && (mode_i == req_mode_o)) req_valid_o <= 1'b0;
      if (stop_c) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (entry) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (expire) begin
        run_q       <= 1'b0;
        cnt_q       <= '0;
        timeout_o   <= 1'b1;
        req_valid_o <= 1'b1;
        req_mode_o  <= target;
      end else if (run_q && tick_i) begin
        cnt_q <= cnt_inc;
      end
    end
  end

  // R11: pulse lasts one cycle
  p_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> !timeout_o);
  // R11: pending request holds until the mode matches
  p_req_held_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && (mode_i != req_mode_o)) |=> req_valid_o);
  // R11: a pulse always comes with a request
  p_pulse_req_r11: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> req_valid_o);
  // R6: supply good in restart blocks expiry
  p_abort_restart_r6: assert property (@(posedge clk) disable iff (rst)
    ((mode_i == M_RESTART) && vcc_good_i) |=> !timeout_o);
  // R7: transaction in standby blocks expiry
  p_abort_standby_r7: assert property (@(posedge clk) disable iff (rst)
    ((mode_i == M_STANDBY) && spi_done_i) |=> !timeout_o);
  // R7: standby expiry with fail-safe enabled asks for fail-safe
  p_target_r7: assert property (@(posedge clk) disable iff (rst)
    (timeout_o && ($past(mode_i) == M_STANDBY) && $past(fs_en_i)) |->
      (req_mode_o == M_FAILSAFE));
  // R10: a running count only exists in a mode that can hang
  p_run_mode_r10: assert property (@(posedge clk) disable iff (rst)
    run_q |-> ((mode_q == M_RESTART) || (mode_q == M_FAILSAFE) ||
               (mode_q == M_STANDBY)));
endmodule

// File: rtl/swe_supervisor.sv
module swe_supervisor #(
  parameter int unsigned TICKS_PER_SEC = 1,
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] CFG_ADDR = 8'h1C,
  parameter logic [DW-1:0] CFG_RESET = 8'h30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic [2:0]    mode_i,
  input  logic          serial_i,
  input  logic          vcc_good_i,
  input  logic          spi_done_i,
  input  logic          fs_en_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  input  logic          reg_we_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          timeout_o,
  output logic          req_valid_o,
  output logic [2:0]    req_mode_o
);
  localparam int unsigned CNT_W = $clog2(swe_pkg::MAX_SECS * TICKS_PER_SEC + 1);

  logic [DW-1:0]    cfg;
  logic [CNT_W-1:0] limit;

  swe_cfg_reg #(.AW(AW), .DW(DW), .REG_ADDR(CFG_ADDR), .RESET_VAL(CFG_RESET)) u_cfg (
    .clk(clk), .rst(rst), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .we_i(reg_we_i), .rdata_o(reg_rdata_o), .cfg_o(cfg)
  );

  swe_limit #(.TICKS_PER_SEC(TICKS_PER_SEC), .CNT_W(CNT_W)) u_limit (
    .code_i(cfg[6:3]), .limit_o(limit)
  );

  swe_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick_i(tick_i), .limit_i(limit), .mode_i(mode_i),
    .serial_i(serial_i), .dis_i(cfg[7]), .vcc_good_i(vcc_good_i),
    .spi_done_i(spi_done_i), .fs_en_i(fs_en_i), .timeout_o(timeout_o),
    .req_valid_o(req_valid_o), .req_mode_o(req_mode_o)
  );

  // R9: serial style with the disable bit set never expires
  p_dis_serial_r9: assert property (@(posedge clk) disable iff (rst)
    (serial_i && cfg[7]) |=> !timeout_o);
endmodule

// File: tb/swe_supervisor_tb_top.sv
module swe_supervisor_tb_top;
  localparam logic [2:0] SLP = 3'd0, STB = 3'd1, RST = 3'd2, FS = 3'd3, NRM = 3'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 0, serial = 0, vcc = 0, spi = 0, fsen = 0, we = 0;
  logic [2:0] mode = NRM;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic timeout, rvalid;
  logic [2:0] rmode;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  swe_supervisor dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .mode_i(mode), .serial_i(serial),
    .vcc_good_i(vcc), .spi_done_i(spi), .fs_en_i(fsen), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_we_i(we), .reg_rdata_o(rdata),
    .timeout_o(timeout), .req_valid_o(rvalid), .req_mode_o(rmode)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk); mode = m;
  endtask

  // Tick up to maxn times; return index of tick that produced the pulse, 0 if none.
  task automatic run_ticks(input int maxn, output int at);
    at = 0;
    for (int i = 1; i <= maxn; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      if (timeout) begin at = i; break; end
    end
  endtask

  task automatic clear_req(input string req, input logic [2:0] m);
    set_mode(m);
    @(negedge clk);
    check({req, " request cleared"}, int'(rvalid), 0);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 timeout low", int'(timeout), 0);
    check("R1 req low", int'(rvalid), 0);
    rd(8'h1C, d);
    check("R1 reset byte", int'(d), 8'h30);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(8'h1B, 8'hFF);
    rd(8'h1C, d);
    check("R2 other-address write ignored", int'(d), 8'h30);
    rd(8'h1B, d);
    check("R2 other address reads 0", int'(d), 0);
    wr(8'h1C, 8'h7D);
    rd(8'h1C, d);
    check("R2 readback", int'(d), 8'h7D);
    wr(8'h1C, 8'h30);
  endtask

  task automatic t_pin_restart;
    int at;
    serial = 0; vcc = 0;
    set_mode(RST);
    run_ticks(310, at);
    check("R3 R4 R6 pin restart default fires at 300", at, 300);
    check("R6 target sleep", int'(rmode), SLP);
    check("R11 req valid", int'(rvalid), 1);
    @(negedge clk);
    check("R11 pulse one cycle", int'(timeout), 0);
    set_mode(RST);
    @(negedge clk);
    check("R11 req held while mode differs", int'(rvalid), 1);
    clear_req("R11", SLP);
  endtask

  task automatic t_pin_standby;
    int at;
    wr(8'h1C, 8'h00);
    serial = 0;
    set_mode(STB);
    run_ticks(60, at);
    check("R4 pin standby does not start", at, 0);
    set_mode(NRM);
  endtask

  task automatic t_pin_failsafe;
    int at;
    serial = 0;
    set_mode(FS);
    run_ticks(40, at);
    check("R4 R8 pin failsafe fires at 30", at, 30);
    check("R8 target sleep", int'(rmode), SLP);
    clear_req("R8", SLP);
  endtask

  task automatic t_restart_abort;
    int at;
    serial = 1; wr(8'h1C, 8'h00);
    set_mode(RST);
    run_ticks(10, at);
    @(negedge clk); vcc = 1;
    @(negedge clk); vcc = 0;
    run_ticks(40, at);
    check("R6 supply good aborts count", at, 0);
    set_mode(NRM);
  endtask

  task automatic t_standby(input logic fe, input int exp_mode);
    int at;
    serial = 1; fsen = fe;
    set_mode(STB);
    run_ticks(40, at);
    check("R5 R7 serial standby fires at 30", at, 30);
    check("R7 standby target", int'(rmode), exp_mode);
  endtask

  task automatic t_standby_fs_chain;
    int at;
    t_standby(1'b1, FS);
    set_mode(FS);
    @(negedge clk);
    check("R11 req cleared on match", int'(rvalid), 0);
    run_ticks(40, at);
    check("R5 R8 failsafe entry restarts count", at, 30);
    check("R8 failsafe target sleep", int'(rmode), SLP);
    clear_req("R8", SLP);
    t_standby(1'b0, SLP);
    clear_req("R7", SLP);
  endtask

  task automatic t_standby_abort;
    int at;
    serial = 1;
    set_mode(STB);
    run_ticks(20, at);
    @(negedge clk); spi = 1;
    @(negedge clk); spi = 0;
    run_ticks(40, at);
    check("R7 transaction aborts count", at, 0);
    set_mode(NRM);
  endtask

  task automatic t_disable;
    int at;
    wr(8'h1C, 8'h80);
    serial = 1;
    set_mode(RST);
    run_ticks(40, at);
    check("R9 serial disable blocks timer", at, 0);
    set_mode(NRM);
    serial = 0;
    set_mode(RST);
    run_ticks(40, at);
    check("R9 pin ignores disable bit", at, 30);
    clear_req("R9", SLP);
  endtask

  task automatic t_reentry;
    int at;
    wr(8'h1C, 8'h00);
    serial = 1;
    set_mode(RST);
    run_ticks(20, at);
    set_mode(NRM);
    run_ticks(5, at);
    set_mode(RST);
    run_ticks(40, at);
    check("R10 re-entry counts full 30", at, 30);
    clear_req("R10", SLP);
  endtask

  task automatic t_change;
    int at;
    wr(8'h1C, 8'h78);
    serial = 1;
    set_mode(RST);
    run_ticks(40, at);
    check("R12 no expiry under code 15", at, 0);
    wr(8'h1C, 8'h00);
    run_ticks(5, at);
    check("R12 shorter code fires on next tick", at, 1);
    clear_req("R12", SLP);
    wr(8'h1C, 8'h08);
    set_mode(RST);
    run_ticks(20, at);
    wr(8'h1C, 8'h00);
    run_ticks(20, at);
    check("R3 R12 code 1 to 0 fires at total 30", at, 10);
    clear_req("R12", SLP);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_pin_restart();
    t_pin_standby();
    t_pin_failsafe();
    t_restart_abort();
    t_standby_fs_chain();
    t_standby_abort();
    t_disable();
    t_reentry();
    t_change();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule